// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped supervisor that checks software keeps running on schedule. A down-counter is loaded with a 12-bit preload value scaled by 2^13 clock ticks (the scale is a parameter). After a 32-bit arming word is written, the counter runs, and nothing except a system reset can stop it. Software keeps it alive with a two-word key handshake. That handshake is honoured only during a closing window at the end of each period, and the window's size is set by a coded register.

A service that arrives too early, or a counter that reaches zero, is a fault. A fault latches a status bit and produces a reaction. The reaction is either a held non-maskable-interrupt level, with the counter reloading and running on, or a one-cycle reset request, with the counter frozen.

Top module: `wwdt_top`

## Requirements
- R1: After reset the block is disarmed: the arming register (0x90) reads 0, the counter (0xA0) reads 0, status (0x98) reads 0, the key register (0x9C) reads 0, the window register (0xA8) reads 0x5, and `nmi_o` and `rst_req_o` are low.
- R2: Writing 0xA98559DA to 0x90 arms the block. In the same edge the counter loads the reload value, preload << SHIFT. The preload is held in the low 12 bits of 0x94. From then on 0x90 reads 0xA98559DA. Any other value written to 0x90 is ignored.
- R3: While armed and not frozen, the counter drops by one each clock until it reaches zero, and 0xA0 reads its current value.
- R4: If the counter is zero at a clock edge and no service happens in that edge, status bit 0 (timeout) is set at that edge.
- R5: A service is the word 0x0000E51A followed by the word 0x0000A35C, each written to 0x9C. Any other word returns the sequence to idle without reloading. Key writes while disarmed or frozen are ignored.
- R6: The window code at 0xA8 selects the open window. 0x50 gives reload>>1, 0x500 gives reload>>2, 0x5000 gives reload>>3, 0x50000 gives reload>>4 and 0x500000 gives reload>>5. Any other code gives the full reload value. A service is in-window when the counter value sampled on the second key write is at most that limit. An in-window service reloads the counter.
- R7: A service outside the window sets status bit 1 (early service).
- R8: If the low 4 bits of 0xA4 are 0xA, a fault reloads the counter and `nmi_o` stays high while status is nonzero. If they hold any other value (reset value 0x5), a fault pulses `rst_req_o` for exactly one cycle and freezes the counter until system reset.
- R9: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R10: Writes to 0x94, 0xA4 and 0xA8 are ignored while the block is armed.
- R11: Once armed, the block cannot be disarmed by any bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, zero when `bus_en` is low |
| nmi_o | output | 1 | Held interrupt level under the NMI reaction |
| rst_req_o | output | 1 | One-cycle reset request under the reset reaction |

## Verification
The bench first targets the window boundary. Random delays place the second key write on either side of the limit for every window code, including an unknown code. A design with an off-by-one error in the window compare, or a wrong shift for a code, would flag a good service or accept an early one. It then targets the expiry cycle: status must still be clear with the counter at zero and set one edge later. A design that fires the fault one cycle early or late, or lets expiry win over a simultaneous service, misses that edge. Finally it checks that broken key sequences, disarm attempts and configuration writes while armed change nothing visible at the ports. It also checks that the reset reaction freezes the counter and produces exactly one pulse, where a design that keeps counting would produce repeated resets.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam logic [7:0] A_ARM   = 8'h90;
  localparam logic [7:0] A_PRLD  = 8'h94;
  localparam logic [7:0] A_STAT  = 8'h98;
  localparam logic [7:0] A_KEY   = 8'h9C;
  localparam logic [7:0] A_CNT   = 8'hA0;
  localparam logic [7:0] A_REACT = 8'hA4;
  localparam logic [7:0] A_WIN   = 8'hA8;

  localparam logic [31:0] ARM_WORD  = 32'hA985_59DA;
  localparam logic [31:0] SVC_WORD0 = 32'h0000_E51A;
  localparam logic [31:0] SVC_WORD1 = 32'h0000_A35C;
  localparam logic [31:0] WIN_RESET = 32'h0000_0005;

  localparam logic [3:0] REACT_NMI = 4'hA;
  localparam logic [3:0] REACT_RST = 4'h5;

  localparam int NUM_WIN = 5;

  typedef enum logic {KS_IDLE, KS_ARMED} keyst_t;
endpackage

// File: rtl/wwdt_keyseq.sv
module wwdt_keyseq
  import wwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr_i,
  input  logic [31:0] key_data_i,
  output logic        svc_try_o
);
  keyst_t st_q, st_d;
  logic   svc_d;

  always_comb begin
    st_d  = st_q;
    svc_d = 1'b0;
    if (key_wr_i) begin
      case (st_q)
        KS_IDLE:  st_d = (key_data_i == SVC_WORD0) ? KS_ARMED : KS_IDLE;
        KS_ARMED: begin
          st_d  = KS_IDLE;
          svc_d = (key_data_i == SVC_WORD1);
        end
        default:  st_d = KS_IDLE;
      endcase
    end
  end

  assign svc_try_o = svc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  // R5
  seq_return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_try_o |=> (st_q == KS_IDLE));
  // R5
  no_double_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_try_o |=> !svc_try_o);
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
  import wwdt_pkg::*;
#(
  parameter int CW = 25
) (
  input  logic [31:0]   wsize_i,
  input  logic [CW-1:0] reload_i,
  input  logic [CW-1:0] cnt_i,
  output logic          win_open_o
);
  logic [NUM_WIN-1:0] hit;
  logic [CW-1:0]      thr [NUM_WIN];
  logic [CW-1:0]      limit;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_code
    assign hit[g] = (wsize_i == (32'h50 << (4 * g)));
    assign thr[g] = reload_i >> (g + 1);
  end

  always_comb begin
    limit = reload_i;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit[i]) limit = thr[i];
    end
  end

  assign win_open_o = (cnt_i <= limit);
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
  parameter int CW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? reload_i : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        nmi_o,
  output logic        rst_req_o
);
  localparam int CW = PRE_W + SHIFT;

  logic [1:0]       rs_q;
  logic             rst_sn;
  logic             en_q, en_d, halt_q, halt_d, rreq_q, rreq_d;
  logic [PRE_W-1:0] prld_q, prld_d;
  logic [3:0]       react_q, react_d;
  logic [31:0]      wsize_q, wsize_d;
  logic [1:0]       stat_q, stat_d, stat_clr;
  logic             wr, running, nmi_sel, arm_hit, key_wr, cfg_en, stat_en;
  logic             svc_try, win_open, svc_ok, svc_bad, expire, fault, load;
  logic [CW-1:0]    reload, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign wr      = bus_en && bus_we;
  assign running = en_q && !halt_q;
  assign nmi_sel = (react_q == REACT_NMI);
  assign reload  = {prld_q, {SHIFT{1'b0}}};
  assign arm_hit = wr && (bus_addr == A_ARM) && (bus_wdata == ARM_WORD) && !en_q;
  assign key_wr  = wr && (bus_addr == A_KEY) && running;
  assign cfg_en  = wr && !en_q;

  wwdt_keyseq u_keys (
    .clk(clk), .rst_n(rst_sn), .key_wr_i(key_wr), .key_data_i(bus_wdata),
    .svc_try_o(svc_try)
  );

  wwdt_window #(.CW(CW)) u_win (
    .wsize_i(wsize_q), .reload_i(reload), .cnt_i(cnt), .win_open_o(win_open)
  );

  wwdt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .load_i(load), .run_i(running),
    .reload_i(reload), .cnt_o(cnt)
  );

  always_comb begin
    svc_ok   = svc_try && win_open;
    svc_bad  = svc_try && !win_open;
    expire   = running && (cnt == '0) && !svc_try;
    fault    = svc_bad || expire;
    load     = arm_hit || svc_ok || (fault && nmi_sel);
    en_d     = en_q || arm_hit;
    halt_d   = halt_q || (fault && !nmi_sel);
    rreq_d   = fault && !nmi_sel;
    prld_d   = (cfg_en && bus_addr == A_PRLD)  ? bus_wdata[PRE_W-1:0] : prld_q;
    react_d  = (cfg_en && bus_addr == A_REACT) ? bus_wdata[3:0]       : react_q;
    wsize_d  = (cfg_en && bus_addr == A_WIN)   ? bus_wdata            : wsize_q;
    stat_clr = (wr && bus_addr == A_STAT) ? bus_wdata[1:0] : 2'b00;
    stat_d   = (stat_q & ~stat_clr) | {svc_bad, expire};
    stat_en  = (stat_clr != 2'b00) || fault;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q    <= 1'b0;
      halt_q  <= 1'b0;
      rreq_q  <= 1'b0;
      prld_q  <= '1;
      react_q <= REACT_RST;
      wsize_q <= WIN_RESET;
      stat_q  <= 2'b00;
    end else begin
      en_q    <= en_d;
      halt_q  <= halt_d;
      rreq_q  <= rreq_d;
      if (cfg_en)  prld_q  <= prld_d;
      if (cfg_en)  react_q <= react_d;
      if (cfg_en)  wsize_q <= wsize_d;
      if (stat_en) stat_q  <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_en) begin
      case (bus_addr)
        A_ARM:   bus_rdata = en_q ? ARM_WORD : 32'h0;
        A_PRLD:  bus_rdata = 32'(prld_q);
        A_STAT:  bus_rdata = 32'(stat_q);
        A_CNT:   bus_rdata = 32'(cnt);
        A_REACT: bus_rdata = 32'(react_q);
        A_WIN:   bus_rdata = wsize_q;
        default: bus_rdata = 32'h0;
      endcase
    end
  end

  assign nmi_o     = nmi_sel && (stat_q != 2'b00);
  assign rst_req_o = rreq_q;

  // R2
  arm_loads_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(en_q) |-> (cnt == reload));
  // R11
  stay_armed_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    en_q |=> en_q);
  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    en_q |=> ($stable(prld_q) && $stable(react_q) && $stable(wsize_q)));
  // R6
  zero_in_window_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt == '0) |-> win_open);
  // R4
  expiry_nmi_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (running && cnt == '0 && !svc_try && nmi_sel) |=> nmi_o);
  // R8
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rst_req_o |=> !rst_req_o);
  // R8
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    halt_q |=> $stable(cnt));
endmodule

// File: tb/sim_wwdt_top.sv
module sim_wwdt_top;
  localparam int PW = 12;
  localparam int SH = 4;

  logic        clk, rst_n, bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        nmi_o, rst_req_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  wwdt_top #(.PRE_W(PW), .SHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic service();
    wr(8'h9C, 32'h0000_E51A);
    wr(8'h9C, 32'h0000_A35C);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] win_code(input int idx);
    if (idx < 5) return 32'h50 << (4 * idx);
    return 32'h0000_0123;
  endfunction

  function automatic int limit_of(input int r, input int idx);
    if (idx < 5) return r >> (idx + 1);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c, h;
    int r, idx, d, pre;
    bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    void'($urandom(32'd2024));
    do_reset();

    // R1 reset state
    rd(8'h90, v); check("R1 arm", v, 0);
    rd(8'h98, v); check("R1 status", v, 0);
    rd(8'hA0, v); check("R1 count", v, 0);
    rd(8'h9C, v); check("R1 key", v, 0);
    rd(8'hA8, v); check("R1 window", v, 32'h5);
    check("R1 nmi", nmi_o, 0);
    check("R1 rstreq", rst_req_o, 0);

    // R2 wrong arming word ignored
    wr(8'h90, 32'hA985_59DB);
    rd(8'h90, v); check("R2 bad arm word", v, 0);

    wr(8'h94, 32'd3); wr(8'hA8, 32'h50); wr(8'hA4, 32'hA);
    rd(8'h94, v); check("R10 preload before arm", v, 3);
    r = 3 << SH;
    wr(8'h90, 32'hA985_59DA);
    rd(8'h90, v); check("R2 arm readback", v, 32'hA985_59DA);
    rd(8'hA0, v); check("R2 load", v, r);

    // R10 config locked, R11 cannot disarm
    wr(8'h94, 32'd7); wr(8'hA4, 32'h5); wr(8'hA8, 32'h5000); wr(8'h90, 32'h0);
    rd(8'h94, v); check("R10 preload lock", v, 3);
    rd(8'hA4, v); check("R10 reaction lock", v, 32'hA);
    rd(8'hA8, v); check("R10 window lock", v, 32'h50);
    rd(8'h90, v); check("R11 still armed", v, 32'hA985_59DA);

    // R3 count down
    rd(8'hA0, c);
    repeat (5) @(negedge clk);
    rd(8'hA0, v); check("R3 decrement", v, c - 5);

    // R7 early service, R8 NMI reaction
    service();
    rd(8'h98, v); check("R7 early flag", v, 2);
    check("R8 nmi level", nmi_o, 1);
    rd(8'hA0, v); check("R8 nmi reload", v, r);

    // R9 write one to clear
    wr(8'h98, 32'h0);
    rd(8'h98, v); check("R9 zero write keeps", v, 2);
    wr(8'h98, 32'h2);
    rd(8'h98, v); check("R9 clear", v, 0);
    check("R9 nmi drop", nmi_o, 0);

    // R5 broken sequence does not reload
    rd(8'hA0, c);
    repeat (c - 20) @(negedge clk);
    wr(8'h9C, 32'h0000_E51A); wr(8'h9C, 32'h0000_1234); wr(8'h9C, 32'h0000_A35C);
    rd(8'hA0, v); check("R5 no reload", v, 17);
    rd(8'h98, v); check("R5 no fault", v, 0);

    // R5 R6 valid in-window service
    service();
    rd(8'hA0, v); check("R5 reload", v, r);
    rd(8'h98, v); check("R6 in window", v, 0);

    // R4 expiry edge
    repeat (r) @(negedge clk);
    rd(8'hA0, v); check("R4 at zero", v, 0);
    rd(8'h98, v); check("R4 not yet", v, 0);
    @(negedge clk);
    rd(8'h98, v); check("R4 timeout", v, 1);
    check("R4 nmi", nmi_o, 1);
    rd(8'hA0, v); check("R8 reload after expiry", v, r);
    wr(8'h98, 32'h1);

    // R8 reset reaction
    do_reset();
    wr(8'h94, 32'd2); wr(8'hA8, 32'h500);
    wr(8'h90, 32'hA985_59DA);
    service();
    rd(8'h98, v); check("R7 early reset mode", v, 2);
    check("R8 reset pulse", rst_req_o, 1);
    check("R8 no nmi", nmi_o, 0);
    rd(8'hA0, h);
    @(negedge clk);
    check("R8 pulse ends", rst_req_o, 0);
    repeat (40) @(negedge clk);
    rd(8'hA0, v); check("R8 frozen", v, h);
    rd(8'h98, v); check("R8 no expiry when frozen", v, 2);
    service();
    rd(8'h98, v); check("R5 keys ignored frozen", v, 2);
    check("R8 single pulse", rst_req_o, 0);

    // R6 R7 random window placement
    for (int k = 0; k < 40; k++) begin
      do_reset();
      idx = $urandom_range(0, 5);
      pre = $urandom_range(2, 6);
      r   = pre << SH;
      wr(8'h94, pre); wr(8'hA8, win_code(idx)); wr(8'hA4, 32'hA);
      wr(8'h90, 32'hA985_59DA);
      d = $urandom_range(0, r - 1);
      repeat (d) @(negedge clk);
      rd(8'hA0, c);
      service();
      rd(8'h98, v);
      check("R6 random window", v, ((int'(c) - 1) <= limit_of(r, idx)) ? 0 : 2);
      rd(8'hA0, v); check("R8 random reload", v, r);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule